// File: doc/BRIEF.md
# DMA Channel Result and Interrupt Unit

This block is the host-facing control and status front end of a 16-channel data mover. For each channel it holds a command-pointer register with an acceptance flag, a four-entry result queue, a status word and a three-bit configuration register. A single shared interrupt status word holds one bit per channel and clears itself when the host reads it. The engine that runs commands and moves memory is outside the block. It reports each event through a one-cycle push that carries a channel number and a four-bit cause. The block hands each accepted command pointer to the engine as a one-cycle issue pulse.

The host drives a plain register port with byte addresses. Bits [8:6] pick a register group and bits [5:2] pick the channel, so channel registers sit four bytes apart. Group 0 is the command pointer (write only, reads 0). Group 1 is the result register (a read pops one entry). Group 2 is status (read only). Group 3 is configuration. Group 4 is the shared interrupt status (read clears; the channel field is ignored). Groups 5 to 7 read as 0. Accesses with address bits [1:0] not zero are ignored. Read data is registered: it appears after the clock edge that samples the read strobe and holds until the next read.

A result word has valid in bit 31, error in bit 3, flush in bit 2, top-pointer done in bit 1 and user-forced in bit 0. A successful completion reads as 0x80000002.

Top module: `dma_result_unit`

## Requirements
- R1: After synchronous reset, every channel has command count 0, no results, configuration 0 and overflow 0. Its status therefore reads 0x00000001 (only ready in bit 0). The interrupt status reads 0 and `irq` and `cmd_valid` are low.
- R2: A write to a channel's command-pointer register while ready (status bit 0) is 1 is accepted. After that edge, `cmd_valid` is high for one cycle with `cmd_ch` and `cmd_ptr` equal to the written channel and data, and the command count (status bits 28:27) goes up by one. Ready is 0 while the count equals 2. A pointer write while ready is 0 issues nothing and leaves the count unchanged.
- R3: An engine push whose cause has error, flush or done set lowers that channel's command count by one when the count is above 0.
- R4: A push is stored in the result queue when its cause has error (bit 3) or user (bit 0) set. It is also stored when done (bit 1) is set with configuration bit 2 at 1, or when flush (bit 2) is set with configuration bit 1 at 1. Otherwise it is not stored.
- R5: A result read returns 0x80000000 OR'd with the cause of the oldest stored entry and removes that entry, in push order. Status bit 1 is 1 while entries remain, and bits 31:29 give the entry count. A read from an empty queue returns 0.
- R6: The result queue holds 4 entries. A storable push into a full queue is dropped and sets the channel's overflow flag (status bit 2). The flag stays set until the next write to that channel's configuration register.
- R7: A push that passes R4 on a channel whose configuration bit 0 is 1 sets that channel's interrupt status bit, even when R6 drops it. `irq` is the OR of all interrupt status bits.
- R8: A read of the interrupt status returns the bits (channel n in bit n) and clears them after that edge. A bit set by a push in the same cycle survives the clear.
- R9: With configuration bit 2 at 1, a push with done alone reads back as 0x80000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 9 | Host byte address: group [8:6], channel [5:2] |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| eng_valid | input | 1 | Engine result push |
| eng_ch | input | 4 | Channel of the push |
| eng_cause | input | 4 | Cause: error, flush, done, user (bits 3..0) |
| cmd_valid | output | 1 | One-cycle pulse for an accepted command pointer |
| cmd_ch | output | 4 | Channel of the issued pointer |
| cmd_ptr | output | 32 | Issued pointer value |
| irq | output | 1 | OR of the interrupt status bits |

## Verification
A wrong read or write pointer in a result queue shows on the next result read as a cause out of push order or a stale word. A wrong entry count shows on the next status read as a wrong value in bits 31:29 or in bit 1. A command count that drifts shows as ready flipping at the wrong point, which the next pointer write exposes through `cmd_valid`. A lost or stuck interrupt bit shows on `irq` right after the push or the clearing read. In every case the error is visible at most one host access after the operation that caused it.

// File: rtl/dru_pkg.sv
package dru_pkg;
    localparam int DW = 32;

    typedef enum logic [2:0] {
        GRP_PTR  = 3'd0,
        GRP_RES  = 3'd1,
        GRP_STAT = 3'd2,
        GRP_CFG  = 3'd3,
        GRP_ISR  = 3'd4
    } grp_e;

    typedef struct packed {
        logic err;
        logic flush;
        logic done;
        logic user;
    } cause_t;

    typedef struct packed {
        logic force_top;
        logic force_flush;
        logic irq_en;
    } cfg_t;

    function automatic logic keep_result(cause_t c, cfg_t g);
        return c.err | c.user | (c.done & g.force_top) | (c.flush & g.force_flush);
    endfunction

    function automatic logic retires_cmd(cause_t c);
        return c.err | c.flush | c.done;
    endfunction

    function automatic logic [DW-1:0] result_word(logic present, cause_t c);
        return present ? {1'b1, 27'b0, c} : '0;
    endfunction
endpackage

// File: rtl/dru_result_fifo.sv
module dru_result_fifo
    import dru_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  cause_t        din_i,
    input  logic          pop_i,
    output cause_t        head_o,
    output logic [CW-1:0] count_o,
    output logic          drop_o
);
    cause_t        mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          full, empty, do_pop, do_push;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop_i & ~empty;
    assign do_push = push_i & (~full | do_pop);
    assign drop_o  = push_i & full & ~do_pop;
    assign head_o  = mem[rp];
    assign count_o = count;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din_i;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: a push into a full queue without a pop leaves the fill level alone
    p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (full && push_i && !pop_i) |=> $stable(count));

    // R5: popping an empty queue with no push keeps it empty
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_i && !push_i) |=> (count == '0));
endmodule

// File: rtl/dru_chan_ctrl.sv
module dru_chan_ctrl
    import dru_pkg::*;
#(
    parameter int CMD_DEPTH = 2,
    localparam int KW = $clog2(CMD_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ptr_wr_i,
    input  logic          cfg_wr_i,
    input  cfg_t          cfg_i,
    input  logic          retire_i,
    input  logic          drop_i,
    output cfg_t          cfg_o,
    output logic [KW-1:0] cmd_cnt_o,
    output logic          ready_o,
    output logic          ovf_o,
    output logic          accept_o
);
    logic [KW-1:0] cnt;
    logic          dec;
    cfg_t          cfg;
    logic          ovf;

    assign ready_o   = (cnt < KW'(CMD_DEPTH));
    assign accept_o  = ptr_wr_i & ready_o;
    assign dec       = retire_i & (cnt != '0);
    assign cmd_cnt_o = cnt;
    assign cfg_o     = cfg;
    assign ovf_o     = ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cfg <= '0;
            ovf <= 1'b0;
        end else begin
            case ({accept_o, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (cfg_wr_i) cfg <= cfg_i;
            ovf <= (ovf & ~cfg_wr_i) | drop_i;
        end
    end

    // R2: a pointer write while busy and no retire leaves the command count alone
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ptr_wr_i && !ready_o && !retire_i) |=> $stable(cnt));

    // R6: overflow stays set until a configuration write
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf && !cfg_wr_i) |=> ovf);
endmodule

// File: rtl/dru_irq_status.sv
module dru_irq_status #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_i,
    input  logic           clr_i,
    output logic [NCH-1:0] isr_o
);
    logic [NCH-1:0] isr;

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (clr_i ? '0 : isr) | set_i;
    end

    assign isr_o = isr;

    // R8: a clearing read with no new event empties the register
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(|set_i)) |=> (isr == '0));

    // R7: bits only drop through a clearing read
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((isr & $past(isr)) == $past(isr)));
endmodule

// File: rtl/dma_result_unit.sv
module dma_result_unit
    import dru_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int RES_DEPTH = 4,
    parameter int CMD_DEPTH = 2,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          eng_valid,
    input  logic [CHW-1:0] eng_ch,
    input  logic [3:0]    eng_cause,
    output logic          cmd_valid,
    output logic [CHW-1:0] cmd_ch,
    output logic [DW-1:0] cmd_ptr,
    output logic          irq
);
    localparam int CW = $clog2(RES_DEPTH + 1);
    localparam int KW = $clog2(CMD_DEPTH + 1);

    grp_e           grp;
    logic [CHW-1:0] sel;
    logic           aligned, wr_ok, rd_ok;
    cause_t         cause;

    assign grp     = grp_e'(host_addr[AW-1:AW-3]);
    assign sel     = host_addr[CHW+1:2];
    assign aligned = (host_addr[1:0] == 2'b00);
    assign wr_ok   = host_wr & aligned;
    assign rd_ok   = host_rd & aligned;
    assign cause   = cause_t'(eng_cause);

    cause_t         head    [NCH];
    logic [CW-1:0]  res_cnt [NCH];
    logic [KW-1:0]  cmd_cnt [NCH];
    cfg_t           cfg     [NCH];
    logic [NCH-1:0] ready, ovf, accept, isr_set;
    logic [NCH-1:0] isr;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic here, hit, keep, drop;
        assign here = eng_valid & (eng_ch == CHW'(i));
        assign hit  = (sel == CHW'(i));
        assign keep = keep_result(cause, cfg[i]);
        assign isr_set[i] = here & keep & cfg[i].irq_en;

        dru_result_fifo #(.DEPTH(RES_DEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push_i  (here & keep),
            .din_i   (cause),
            .pop_i   (rd_ok & hit & (grp == GRP_RES)),
            .head_o  (head[i]),
            .count_o (res_cnt[i]),
            .drop_o  (drop)
        );

        dru_chan_ctrl #(.CMD_DEPTH(CMD_DEPTH)) u_ctrl (
            .clk       (clk),
            .rst       (rst),
            .ptr_wr_i  (wr_ok & hit & (grp == GRP_PTR)),
            .cfg_wr_i  (wr_ok & hit & (grp == GRP_CFG)),
            .cfg_i     (cfg_t'(host_wdata[2:0])),
            .retire_i  (here & retires_cmd(cause)),
            .drop_i    (drop),
            .cfg_o     (cfg[i]),
            .cmd_cnt_o (cmd_cnt[i]),
            .ready_o   (ready[i]),
            .ovf_o     (ovf[i]),
            .accept_o  (accept[i])
        );
    end

    dru_irq_status #(.NCH(NCH)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (isr_set),
        .clr_i (rd_ok & (grp == GRP_ISR)),
        .isr_o (isr)
    );

    logic [DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (grp)
            GRP_RES:  rd_mux = result_word(res_cnt[sel] != '0, head[sel]);
            GRP_STAT: rd_mux = {3'(res_cnt[sel]), 2'(cmd_cnt[sel]), 24'b0,
                                ovf[sel], (res_cnt[sel] != '0), ready[sel]};
            GRP_CFG:  rd_mux = {29'b0, cfg[sel]};
            GRP_ISR:  rd_mux = DW'(isr);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
            cmd_valid  <= 1'b0;
            cmd_ch     <= '0;
            cmd_ptr    <= '0;
        end else begin
            if (rd_ok) host_rdata <= rd_mux;
            cmd_valid <= |accept;
            if (|accept) begin
                cmd_ch  <= sel;
                cmd_ptr <= host_wdata;
            end
        end
    end

    assign irq = |isr;

    // R7: the interrupt line only rises after an enabled stored event
    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|isr_set));

    // R2: at most one channel accepts a pointer per cycle
    p_one_accept_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(accept));
endmodule

// File: tb/dma_result_unit_tb.sv
module dma_result_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr = 0, host_rd = 0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_valid = 0;
    logic [3:0]  eng_ch = '0, eng_cause = '0;
    logic        cmd_valid;
    logic [3:0]  cmd_ch;
    logic [31:0] cmd_ptr;
    logic        irq;

    always #5 clk = ~clk;

    dma_result_unit dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_valid(eng_valid), .eng_ch(eng_ch), .eng_cause(eng_cause),
        .cmd_valid(cmd_valid), .cmd_ch(cmd_ch), .cmd_ptr(cmd_ptr), .irq(irq)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    // reference model
    int         mcnt [16];
    logic [2:0] mcfg [16];
    logic [3:0] mq   [16][$];
    bit         movf [16];
    logic [15:0] misr;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] adr(logic [2:0] g, logic [3:0] ch);
        return {g, ch, 2'b00};
    endfunction

    function automatic bit m_keep(logic [3:0] c, logic [2:0] g);
        return c[3] | c[0] | (c[1] & g[2]) | (c[2] & g[1]);
    endfunction

    function automatic logic [31:0] m_status(int ch);
        int n = mq[ch].size();
        return {3'(n), 2'(mcnt[ch]), 24'b0, movf[ch], (n != 0), (mcnt[ch] < 2)};
    endfunction

    task automatic m_push(int ch, logic [3:0] c);
        if ((c[3] | c[2] | c[1]) && mcnt[ch] > 0) mcnt[ch]--;
        if (m_keep(c, mcfg[ch])) begin
            if (mq[ch].size() < 4) mq[ch].push_back(c);
            else movf[ch] = 1;
            if (mcfg[ch][0]) misr[ch] = 1'b1;
        end
    endtask

    task automatic op_ptr(logic [3:0] ch, logic [31:0] d);
        bit acc;
        @(negedge clk);
        host_wr = 1; host_addr = adr(3'd0, ch); host_wdata = d;
        @(posedge clk); #1;
        host_wr = 0;
        acc = (mcnt[ch] < 2);
        if (acc) mcnt[ch]++;
        check("R2 cmd_valid", 32'(cmd_valid), 32'(acc));
        if (acc) begin
            check("R2 cmd_ch", 32'(cmd_ch), 32'(ch));
            check("R2 cmd_ptr", cmd_ptr, d);
        end
    endtask

    task automatic op_cfg(logic [3:0] ch, logic [2:0] g);
        @(negedge clk);
        host_wr = 1; host_addr = adr(3'd3, ch); host_wdata = {29'b0, g};
        @(posedge clk); #1;
        host_wr = 0;
        mcfg[ch] = g; movf[ch] = 0;
    endtask

    task automatic op_push(logic [3:0] ch, logic [3:0] c, bit isr_rd);
        logic [31:0] exp_isr;
        @(negedge clk);
        eng_valid = 1; eng_ch = ch; eng_cause = c;
        if (isr_rd) begin host_rd = 1; host_addr = adr(3'd4, 4'd0); end
        @(posedge clk); #1;
        eng_valid = 0; host_rd = 0;
        exp_isr = 32'(misr);
        if (isr_rd) misr = '0;
        m_push(ch, c);
        if (isr_rd) check("R8 isr read with push", host_rdata, exp_isr);
        check("R7 irq after push", 32'(irq), 32'(|misr));
    endtask

    task automatic op_read(logic [2:0] g, logic [3:0] ch);
        logic [31:0] exp;
        @(negedge clk);
        host_rd = 1; host_addr = adr(g, ch);
        @(posedge clk); #1;
        host_rd = 0;
        case (g)
            3'd1: begin
                if (mq[ch].size() == 0) exp = '0;
                else exp = {1'b1, 27'b0, mq[ch].pop_front()};
                check("R5 result read", host_rdata, exp);
            end
            3'd2: check("R5 status read", host_rdata, m_status(ch));
            3'd3: check("R4 config read", host_rdata, {29'b0, mcfg[ch]});
            3'd4: begin
                check("R8 isr read", host_rdata, 32'(misr));
                misr = '0;
                check("R8 irq after clear", 32'(irq), 32'h0);
            end
            default: check("R1 unmapped read", host_rdata, 32'h0);
        endcase
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (mcnt[i]) begin mcnt[i] = 0; mcfg[i] = '0; movf[i] = 0; end
        misr = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 cmd_valid", 32'(cmd_valid), 0);
        op_read(3'd2, 4'd0);
        check("R1 status ch0", host_rdata, 32'h0000_0001);
        op_read(3'd4, 4'd0);
        op_read(3'd1, 4'd9);

        // R2: fill command slots, then refuse
        op_ptr(4'd3, 32'hABCD_0008);
        op_ptr(4'd3, 32'h1234_5670);
        op_read(3'd2, 4'd3);
        check("R2 busy status", host_rdata, 32'h1000_0000);
        op_ptr(4'd3, 32'hDEAD_BEE8);
        op_read(3'd2, 4'd3);

        // R3/R4: done without force: retires, not stored
        op_push(4'd3, 4'b0010, 0);
        op_read(3'd2, 4'd3);
        check("R3 retire status", host_rdata, 32'h0800_0001);
        op_read(3'd1, 4'd3);
        check("R4 not stored", host_rdata, 32'h0);

        // R9: success value with force top and irq enable
        op_cfg(4'd3, 3'b101);
        op_push(4'd3, 4'b0010, 0);
        check("R7 irq raised", 32'(irq), 1);
        op_read(3'd1, 4'd3);
        check("R9 success word", host_rdata, 32'h8000_0002);
        op_read(3'd4, 4'd0);

        // R6: overflow on flush results
        op_cfg(4'd5, 3'b010);
        for (int k = 0; k < 6; k++) op_push(4'd5, 4'b0100, 0);
        op_read(3'd2, 4'd5);
        check("R6 full with overflow", host_rdata, 32'h8000_0007);
        for (int k = 0; k < 5; k++) op_read(3'd1, 4'd5);
        op_read(3'd2, 4'd5);
        check("R6 overflow sticky", host_rdata, 32'h0000_0005);
        op_cfg(4'd5, 3'b010);
        op_read(3'd2, 4'd5);
        check("R6 overflow cleared", host_rdata, 32'h0000_0001);

        // R8: set during clearing read survives
        op_cfg(4'd2, 3'b001);
        op_cfg(4'd1, 3'b001);
        op_push(4'd2, 4'b0001, 0);
        op_push(4'd1, 4'b0001, 1);
        check("R8 surviving bit", 32'(irq), 1);
        op_read(3'd4, 4'd0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 9);
            logic [3:0] ch = 4'($urandom_range(0, 3) * 4 + $urandom_range(0, 1));
            case (op)
                0, 1:    op_ptr(ch, $urandom() & 32'hFFFF_FFF8);
                2, 3, 4: op_push(ch, 4'($urandom_range(0, 15)), ($urandom_range(0, 7) == 0));
                5:       op_read(3'd1, ch);
                6:       op_read(3'd2, ch);
                7:       op_read(3'd4, ch);
                8:       op_cfg(ch, 3'($urandom_range(0, 7)));
                default: op_read(3'($urandom_range(3, 7)), ch);
            endcase
        end

        for (int c = 0; c < 16; c++) op_read(3'd2, 4'(c));

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule